// File: doc/BRIEF.md
# Three-Channel PS/2 Receive Arbiter

This block is a single receive shift engine shared by three PS/2 device ports. Each port has an open-drain clock line and an open-drain data line. The block can only pull a line low; a released line reads high. While idle, the engine watches every enabled port for a start bit. It locks onto the first port that sends one. It then holds the clocks of the other ports low, so that those devices abandon their transfers and retry later.

After the lock, the engine shifts in the rest of the 11-bit frame from the chosen port: eight data bits with the least significant bit first, then an odd-parity bit, then a stop bit. It latches the byte, the active port number and flags for parity and framing errors. When the frame ends, it pulls all three clocks low and stays parked until reset. A start-of-transfer request and an end-of-transfer request are each gated by their own enable input.

Top module: `ps2_rx_arbiter`

## Requirements
- R1: After reset, all flags are clear, `act_ch` is 0, `rx_byte` is 0, and in idle `ps2_clk_oe` equals the inverse of `ch_en` (bit 0 is port 1).
- R2: A start bit is a falling edge on an enabled port's clock while its data line is low. Accepting it sets `sot_flag` and loads `act_ch` with the port number (1, 2 or 3).
- R3: Once a port is selected, start bits on other ports are ignored and `act_ch` does not change.
- R4: When start bits appear on several ports in the same cycle, the lowest port number is selected.
- R5: While a frame is being received, the clock drive-low output is asserted for every port except the active one.
- R6: Falling edges 2 to 9 of the active port sample data bits least significant first, and the byte appears on `rx_byte` when the frame ends.
- R7: `par_err` is set when the number of ones across the eight data bits and the parity bit (edge 10) is even.
- R8: If data is low on edge 11, `frm_err` is set, and that edge still ends the frame.
- R9: At frame end, `eot_flag` is set and all three clock drive-low outputs are asserted. Both stay so, and the results stay unchanged, until reset.
- R10: `sot_irq` equals `sot_flag` AND `sot_ie`, and `eot_irq` equals `eot_flag` AND `eot_ie`.
- R11: A port whose `ch_en` bit is 0 is held low in idle, and its activity never selects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | 3 | Per-port receive enable, bit 0 = port 1 |
| sot_ie | input | 1 | Start-of-transfer request enable |
| eot_ie | input | 1 | End-of-transfer request enable |
| ps2_clk_i | input | 3 | Sensed clock line level per port |
| ps2_dat_i | input | 3 | Sensed data line level per port |
| ps2_clk_oe | output | 3 | Pull clock line low, per port |
| ps2_dat_oe | output | 3 | Pull data line low, per port (always 0 in receive) |
| sot_flag | output | 1 | Start bit accepted |
| eot_flag | output | 1 | Frame complete |
| par_err | output | 1 | Parity error on the received frame |
| frm_err | output | 1 | Stop bit was low |
| act_ch | output | 2 | Selected port, 1 to 3, 0 when none |
| rx_byte | output | 8 | Received data byte |
| sot_irq | output | 1 | Start-of-transfer request |
| eot_irq | output | 1 | End-of-transfer request |

## Verification
Single frames are sent on different ports, with clean bytes, a wrong parity bit and a low stop bit. This separates correct bit order, the parity sense and the framing check. Two ports that start in the same cycle show the tie rule. A port that starts a few device bit-times after another shows that the first arrival wins and that the loser's clock is held low. A frame on a disabled port shows that enables gate selection, and a frame sent after completion shows that the parked state holds its results.

// File: rtl/ps2_rx_pkg.sv
`timescale 1ns/1ps
package ps2_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DONE   = 2'd2
  } rx_state_e;
endpackage

// File: rtl/ps2_line_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer per line plus clock falling-edge detection.
module ps2_line_sync #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] clk_i,
  input  logic [NCH-1:0] dat_i,
  output logic [NCH-1:0] clk_fall,
  output logic [NCH-1:0] dat_s
);
  logic [NCH-1:0] clk_q1, clk_q2, clk_q3;
  logic [NCH-1:0] dat_q1, dat_q2;

  for (genvar g = 0; g < NCH; g++) begin : g_line
    // released lines idle high, so reset to 1 to avoid a false edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        clk_q1[g] <= 1'b1;
        clk_q2[g] <= 1'b1;
        clk_q3[g] <= 1'b1;
        dat_q1[g] <= 1'b1;
        dat_q2[g] <= 1'b1;
      end else begin
        clk_q1[g] <= clk_i[g];
        clk_q2[g] <= clk_q1[g];
        clk_q3[g] <= clk_q2[g];
        dat_q1[g] <= dat_i[g];
        dat_q2[g] <= dat_q1[g];
      end
    end
  end

  assign clk_fall = clk_q3 & ~clk_q2;
  assign dat_s    = dat_q2;
endmodule

// File: rtl/ps2_start_arb.sv
`timescale 1ns/1ps
// Fixed-priority selector: lowest index wins.
module ps2_start_arb #(
  parameter int NCH  = 3,
  localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0]  req,
  output logic [NCH-1:0]  grant,
  output logic [IDXW-1:0] idx,
  output logic            any
);
  always_comb begin
    idx   = '0;
    grant = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx   = IDXW'(i);
        grant = NCH'(1) << i;
      end
    end
    any = |req;
  end

  always_comb begin
    assert_grant_onehot_R4: assert ($onehot0(grant));
  end
endmodule

// File: rtl/ps2_frame_shifter.sv
`timescale 1ns/1ps
// Counts post-start edges, shifts data LSB first, captures parity, ends on stop.
module ps2_frame_shifter #(
  parameter int DW = 8,
  localparam int NBITS = DW + 2,
  localparam int CW = $clog2(NBITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          bit_en,
  input  logic          bit_val,
  output logic [DW-1:0] data,
  output logic          frame_done,
  output logic          par_bad,
  output logic          stop_bad
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          par_q, par_d;

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    par_d = par_q;
    if (start) begin
      cnt_d = '0;
    end else if (bit_en) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q < CW'(DW))  sh_d  = {bit_val, sh_q[DW-1:1]};
      if (cnt_q == CW'(DW)) par_d = bit_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
      par_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      par_q <= par_d;
    end
  end

  assign frame_done = bit_en && !start && (cnt_q == CW'(NBITS - 1));
  assign data       = sh_q;
  assign par_bad    = ~(^{sh_q, par_q});
  assign stop_bad   = ~bit_val;

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(NBITS));
endmodule

// File: rtl/ps2_rx_arbiter.sv
`timescale 1ns/1ps
module ps2_rx_arbiter #(
  parameter int NCH = 3,
  parameter int DW  = 8,
  localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CHW  = $clog2(NCH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ch_en,
  input  logic           sot_ie,
  input  logic           eot_ie,
  input  logic [NCH-1:0] ps2_clk_i,
  input  logic [NCH-1:0] ps2_dat_i,
  output logic [NCH-1:0] ps2_clk_oe,
  output logic [NCH-1:0] ps2_dat_oe,
  output logic           sot_flag,
  output logic           eot_flag,
  output logic           par_err,
  output logic           frm_err,
  output logic [CHW-1:0] act_ch,
  output logic [DW-1:0]  rx_byte,
  output logic           sot_irq,
  output logic           eot_irq
);
  import ps2_rx_pkg::*;

  rx_state_e      state_q, state_d;
  logic [IDXW-1:0] sel_q;
  logic [NCH-1:0] clk_fall, dat_s, start_req, grant;
  logic [IDXW-1:0] win_idx;
  logic           win_any, accept, bit_en, frame_done, par_bad, stop_bad;
  logic [DW-1:0]  sh_data;

  ps2_line_sync #(.NCH(NCH)) u_sync (
    .clk(clk), .rst_n(rst_n), .clk_i(ps2_clk_i), .dat_i(ps2_dat_i),
    .clk_fall(clk_fall), .dat_s(dat_s));

  assign start_req = clk_fall & ~dat_s & ch_en;

  ps2_start_arb #(.NCH(NCH)) u_arb (
    .req(start_req), .grant(grant), .idx(win_idx), .any(win_any));

  assign accept = (state_q == ST_IDLE) && win_any;
  assign bit_en = (state_q == ST_ACTIVE) && clk_fall[sel_q];

  ps2_frame_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(accept), .bit_en(bit_en),
    .bit_val(dat_s[sel_q]), .data(sh_data), .frame_done(frame_done),
    .par_bad(par_bad), .stop_bad(stop_bad));

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (accept)     state_d = ST_ACTIVE;
      ST_ACTIVE: if (frame_done) state_d = ST_DONE;
      default:                   state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sel_q    <= '0;
      sot_flag <= 1'b0;
      eot_flag <= 1'b0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
      act_ch   <= '0;
      rx_byte  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        sel_q    <= win_idx;
        sot_flag <= 1'b1;
        act_ch   <= CHW'(win_idx) + 1'b1;
      end
      if (frame_done) begin
        eot_flag <= 1'b1;
        par_err  <= par_bad;
        frm_err  <= stop_bad;
        rx_byte  <= sh_data;
      end
    end
  end

  always_comb begin
    case (state_q)
      ST_IDLE:   ps2_clk_oe = ~ch_en;
      ST_ACTIVE: ps2_clk_oe = ~(NCH'(1) << sel_q);
      default:   ps2_clk_oe = '1;
    endcase
  end

  assign ps2_dat_oe = '0;
  assign sot_irq    = sot_flag & sot_ie;
  assign eot_irq    = eot_flag & eot_ie;

  assert_inhibit_others_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sot_flag && !eot_flag) |-> ($countones(ps2_clk_oe) == NCH - 1));
  assert_sel_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sot_flag |=> $stable(act_ch));
  assert_eot_parked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eot_flag |=> (eot_flag && ps2_clk_oe == '1 && $stable(rx_byte)));
  assert_sot_before_eot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eot_flag |-> (sot_flag && act_ch != '0));
endmodule

// File: tb/ps2_rx_arbiter_bench.sv
`timescale 1ns/1ps
module ps2_rx_arbiter_bench;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] ch_en;
  logic sot_ie, eot_ie;
  logic [2:0] dev_clk, dev_dat;
  logic [2:0] line_clk, line_dat, clk_oe, dat_oe;
  logic sot_flag, eot_flag, par_err, frm_err, sot_irq, eot_irq;
  logic [1:0] act_ch;
  logic [7:0] rx_byte;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct { logic [1:0] ch; logic [7:0] b; logic pe; logic fe; } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  assign line_clk = dev_clk & ~clk_oe;
  assign line_dat = dev_dat & ~dat_oe;

  ps2_rx_arbiter u_ps2_rx_arbiter (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .sot_ie(sot_ie), .eot_ie(eot_ie),
    .ps2_clk_i(line_clk), .ps2_dat_i(line_dat),
    .ps2_clk_oe(clk_oe), .ps2_dat_oe(dat_oe),
    .sot_flag(sot_flag), .eot_flag(eot_flag), .par_err(par_err),
    .frm_err(frm_err), .act_ch(act_ch), .rx_byte(rx_byte),
    .sot_irq(sot_irq), .eot_irq(eot_irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    dev_clk = 3'b111;
    dev_dat = 3'b111;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // device-side frame generator on port index ch (0..2)
  task automatic send_frame(input int ch, input logic [7:0] b,
                            input logic good_par, input logic good_stop);
    logic [10:0] f;
    f = {good_stop, (good_par ? ~^b : ^b), b, 1'b0};
    for (int k = 0; k < 11; k++) begin
      dev_dat[ch] = f[k];
      repeat (H) @(negedge clk);
      dev_clk[ch] = 1'b0;
      repeat (H) @(negedge clk);
      dev_clk[ch] = 1'b1;
    end
    dev_dat[ch] = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic push(input logic [1:0] ch, input logic [7:0] b, input logic pe, input logic fe);
    exp_t e;
    e.ch = ch; e.b = b; e.pe = pe; e.fe = fe;
    exp_q.push_back(e);
  endtask

  // monitor: compare each completed frame with the queued expectation
  initial begin
    forever begin
      @(posedge eot_flag);
      @(negedge clk);
      if (exp_q.size() == 0) begin
        chk("R9 unexpected frame end", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R2 act_ch", 32'(act_ch), 32'(e.ch));
        chk("R6 rx_byte", 32'(rx_byte), 32'(e.b));
        chk("R7 par_err", 32'(par_err), 32'(e.pe));
        chk("R8 frm_err", 32'(frm_err), 32'(e.fe));
        chk("R9 all clocks low", 32'(clk_oe), 32'h7);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    ch_en = 3'b111; sot_ie = 1'b0; eot_ie = 1'b0;
    do_reset();
    // R1 reset state
    chk("R1 sot_flag", 32'(sot_flag), 0);
    chk("R1 eot_flag", 32'(eot_flag), 0);
    chk("R1 act_ch", 32'(act_ch), 0);
    chk("R1 rx_byte", 32'(rx_byte), 0);
    chk("R1 idle clk_oe", 32'(clk_oe), 0);

    // R2 R6 clean frame on port 1
    push(2'd1, 8'hA5, 1'b0, 1'b0);
    send_frame(0, 8'hA5, 1'b1, 1'b1);
    repeat (4) @(negedge clk);
    chk("R2 sot_flag", 32'(sot_flag), 1);

    // R9 parked: another frame changes nothing
    send_frame(0, 8'h11, 1'b1, 1'b1);
    chk("R9 rx_byte held", 32'(rx_byte), 32'hA5);
    chk("R9 eot held", 32'(eot_flag), 1);
    chk("R9 clk_oe held", 32'(clk_oe), 32'h7);

    // R7 parity error on port 3, R10 request gating
    do_reset();
    sot_ie = 1'b1;
    push(2'd3, 8'h3C, 1'b1, 1'b0);
    send_frame(2, 8'h3C, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    chk("R10 sot_irq", 32'(sot_irq), 1);
    chk("R10 eot_irq off", 32'(eot_irq), 0);
    eot_ie = 1'b1;
    #1;
    chk("R10 eot_irq on", 32'(eot_irq), 1);
    sot_ie = 1'b0;
    #1;
    chk("R10 sot_irq off", 32'(sot_irq), 0);
    eot_ie = 1'b0;

    // R8 framing error on port 2
    do_reset();
    push(2'd2, 8'h81, 1'b0, 1'b1);
    send_frame(1, 8'h81, 1'b1, 1'b0);
    repeat (4) @(negedge clk);

    // R4 tie between ports 2 and 3, with R5 mid-frame inhibit check
    do_reset();
    push(2'd2, 8'h5A, 1'b0, 1'b0);
    fork
      send_frame(1, 8'h5A, 1'b1, 1'b1);
      send_frame(2, 8'hFF, 1'b1, 1'b1);
      begin
        wait (sot_flag);
        repeat (2) @(negedge clk);
        chk("R4 tie act_ch", 32'(act_ch), 2);
        chk("R5 inhibit others", 32'(clk_oe), 32'h5);
      end
    join
    repeat (4) @(negedge clk);

    // R3 first start wins: port 3 starts, port 1 three bit-times later
    do_reset();
    push(2'd3, 8'hC3, 1'b0, 1'b0);
    fork
      send_frame(2, 8'hC3, 1'b1, 1'b1);
      begin
        repeat (6 * H) @(negedge clk);
        send_frame(0, 8'h00, 1'b1, 1'b1);
      end
    join
    repeat (4) @(negedge clk);
    chk("R3 later start ignored", 32'(act_ch), 3);

    // R11 disabled port 1 is held low and never selected
    ch_en = 3'b110;
    do_reset();
    chk("R11 idle clk_oe", 32'(clk_oe), 32'h1);
    send_frame(0, 8'h77, 1'b1, 1'b1);
    chk("R11 no selection", 32'(sot_flag), 0);
    push(2'd2, 8'h0F, 1'b0, 1'b0);
    send_frame(1, 8'h0F, 1'b1, 1'b1);
    repeat (4) @(negedge clk);

    chk("scoreboard drained", 32'(exp_q.size()), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule